// File: doc/BRIEF.md
# Programmable Chip-Select Decoder with Wait States

This block produces the chip selects for a 32-bit bus master. It holds eight banks, and each bank has a base word and an option word. Software loads these words through a one-cycle register-write port. When the master raises its address strobe, every enabled bank compares the address and the function code against its own programmed window. The lowest-numbered bank that accepts the cycle drives its active-low select. The block also drives that bank's port-size code. It counts the programmed number of wait states and then pulses the transfer acknowledge.

A cycle that no bank accepts raises a one-cycle no-match pulse instead, so that an external bus-error path can end it. The following cycles are rejected by every bank:
- cycles in CPU space;
- write cycles to a bank that is programmed as read-only.

Bank words (bank-select field `reg_addr_i[2:0]`, word select `reg_addr_i[3]`, 0 = base, 1 = option):
- base word: `[27:11]` base address, `[10:7]` function-code value, `[2]` write enable (1 = writes allowed), `[0]` valid.
- option word: `[27:11]` address mask, `[10:7]` function-code mask, `[5:4]` port size, `[3:0]` cycle-length code.

Top module: `csel_unit`

## Requirements
- R1: After reset every select is high (`cs_no` = 8'hFF), `ta_o`, `nomatch_o` and `port_size_o` are 0, and all valid bits are clear, so the first strobed cycle gives a no-match.
- R2: A bank matches when address bits 27..11 equal its base bits wherever its option mask bit is 1. A mask bit of 0 makes that address bit a don't-care. Address bits 31..28 and 10..0 never affect decoding.
- R3: A bank takes part in decoding only while bit 0 of its base word is 1. Clearing that bit removes the bank.
- R4: Function-code bits whose option mask bit (option `[10:7]`) is 1 must equal base `[10:7]`, and a zero mask accepts every code. A cycle with `fc_i` = 4'b0111 (CPU space) never asserts any select.
- R5: When several banks accept a cycle, only the lowest-numbered one is selected, and at most one select is low at any time.
- R6: Cycle-length code c (option `[3:0]`) gives max(c-1,0) wait states. `ta_o` rises that many cycles after the first cycle with the select low, and it lasts exactly one cycle.
- R7: While a select is low, `port_size_o` carries option `[5:4]` of that bank (2'b10 means an 8-bit port). Otherwise `port_size_o` is 0.
- R8: A write cycle (`rw_i` = 0) is not accepted by a bank whose base bit 2 is 0. Read cycles to that bank are still accepted, and other banks may still accept the write.
- R9: A cycle that no bank accepts gives a one-cycle `nomatch_o` pulse one cycle after the strobe is sampled. It asserts no select and no `ta_o`.
- R10: The select goes low in the cycle after the strobe is first sampled high. It stays low through the acknowledge cycle and goes high in the next cycle, even while the strobe is held. A new cycle starts only after the strobe has been low.
- R11: A register write with `reg_addr_i[3]` = 0 loads the base word, and with 1 loads the option word, of bank `reg_addr_i[2:0]`. No other bank changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Word select (bit 3) and bank index (bits 2..0) |
| reg_wdata_i | input | 32 | Register write data |
| as_i | input | 1 | Address strobe, active high |
| addr_i | input | 32 | Bus address |
| fc_i | input | 4 | Function code |
| rw_i | input | 1 | 1 = read, 0 = write |
| cs_no | output | 8 | Active-low bank selects |
| port_size_o | output | 2 | Port-size code of the selected bank |
| ta_o | output | 1 | Transfer acknowledge |
| nomatch_o | output | 1 | No bank accepted the cycle |

## Verification
Addresses are chosen in several ways:
- inside small and large windows;
- with the ignored upper nibble set;
- just past a window's edge.

These separate a wrong mask polarity or bit range from a correct compare. Overlapping banks, with the lower bank later disabled, show whether priority and the valid gate work. Function codes that match, do not match and fall in CPU space test the code mask. Reads and writes to a read-only bank, with a writable bank behind it, test the write permission. Cycle codes 0, 1, 2, 3 and 15, with the strobe held past the acknowledge, test the offset wait count, its saturation and the release of the select.

// File: rtl/csel_pkg.sv
package csel_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_ACT, ST_ERR, ST_DONE} cyc_st_e;

  localparam int unsigned WORD_W    = 32;
  localparam int unsigned FC_W      = 4;
  localparam int unsigned TC_W      = 4;
  localparam int unsigned PS_W      = 2;
  localparam int unsigned VALID_BIT = 0;
  localparam int unsigned WREN_BIT  = 2;
  localparam int unsigned FC_LSB    = 7;
  localparam int unsigned TC_LSB    = 0;
  localparam int unsigned PS_LSB    = 4;
  localparam logic [WORD_W-1:0] ADR_CMP_MASK = 32'h0FFF_F800;
  localparam logic [FC_W-1:0]   FC_CPU_SPACE = 4'b0111;
endpackage

// File: rtl/csel_regs.sv
module csel_regs
  import csel_pkg::*;
#(
  parameter int unsigned NBANK = 8,
  localparam int unsigned BSEL_W = $clog2(NBANK),
  localparam int unsigned RA_W = BSEL_W + 1
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           we_i,
  input  logic [RA_W-1:0]                addr_i,
  input  logic [WORD_W-1:0]              wdata_i,
  output logic [NBANK-1:0][WORD_W-1:0]   base_o,
  output logic [NBANK-1:0][WORD_W-1:0]   opt_o
);
  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic hit_bank;
    assign hit_bank = we_i && (addr_i[BSEL_W-1:0] == BSEL_W'(b));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        base_o[b] <= '0;
        opt_o[b]  <= '0;
      end else if (hit_bank) begin
        if (addr_i[RA_W-1]) opt_o[b]  <= wdata_i;
        else                base_o[b] <= wdata_i;
      end
    end
  end

  // R11: a write leaves the base word of every other bank as it was
  for (genvar b = 0; b < NBANK; b++) begin : g_chk
    AST_OTHER_BANK_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && addr_i[BSEL_W-1:0] != BSEL_W'(b)) |=> $stable(base_o[b])); // R11
  end
endmodule

// File: rtl/csel_match.sv
module csel_match
  import csel_pkg::*;
#(
  parameter int unsigned NBANK = 8
) (
  input  logic [NBANK-1:0][WORD_W-1:0] base_i,
  input  logic [NBANK-1:0][WORD_W-1:0] opt_i,
  input  logic [WORD_W-1:0]            addr_i,
  input  logic [FC_W-1:0]              fc_i,
  input  logic                         rw_i,
  output logic [NBANK-1:0]             hit_o
);
  logic cpu_space;
  assign cpu_space = (fc_i == FC_CPU_SPACE);

  for (genvar b = 0; b < NBANK; b++) begin : g_cmp
    logic adr_ok, fc_ok, acc_ok;
    assign adr_ok = ((addr_i ^ base_i[b]) & opt_i[b] & ADR_CMP_MASK) == '0;
    assign fc_ok  = ((fc_i ^ base_i[b][FC_LSB +: FC_W]) & opt_i[b][FC_LSB +: FC_W]) == '0;
    assign acc_ok = rw_i || base_i[b][WREN_BIT];
    assign hit_o[b] = base_i[b][VALID_BIT] && adr_ok && fc_ok && acc_ok && !cpu_space;
  end
endmodule

// File: rtl/csel_cycle.sv
module csel_cycle
  import csel_pkg::*;
#(
  parameter int unsigned NBANK = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             as_i,
  input  logic [NBANK-1:0] sel_i,
  input  logic [PS_W-1:0]  ps_i,
  input  logic [TC_W-1:0]  code_i,
  output logic [NBANK-1:0] cs_no,
  output logic [PS_W-1:0]  port_size_o,
  output logic             ta_o,
  output logic             nomatch_o
);
  cyc_st_e          st_q;
  logic [NBANK-1:0] sel_q;
  logic [PS_W-1:0]  ps_q;
  logic [TC_W-1:0]  cnt_q;
  logic [TC_W-1:0]  waits;

  // offset-by-one code, saturating at zero
  assign waits = (code_i == '0) ? '0 : code_i - TC_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      sel_q <= '0;
      ps_q  <= '0;
      cnt_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (as_i) begin
          if (sel_i != '0) begin
            st_q  <= ST_ACT;
            sel_q <= sel_i;
            ps_q  <= ps_i;
            cnt_q <= waits;
          end else begin
            st_q <= ST_ERR;
          end
        end
        ST_ACT:  if (cnt_q == '0) st_q <= ST_DONE;
                 else cnt_q <= cnt_q - TC_W'(1);
        ST_ERR:  st_q <= ST_DONE;
        ST_DONE: if (!as_i) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign cs_no       = (st_q == ST_ACT) ? ~sel_q : '1;
  assign port_size_o = (st_q == ST_ACT) ? ps_q : '0;
  assign ta_o        = (st_q == ST_ACT) && (cnt_q == '0);
  assign nomatch_o   = (st_q == ST_ERR);

  AST_TA_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ta_o |=> !ta_o); // R6
  AST_TA_UNDER_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ta_o |-> (cs_no != '1)); // R10
  AST_CS_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ta_o |=> (cs_no == '1)); // R10
  AST_NOMATCH_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nomatch_o |=> !nomatch_o); // R9
  AST_NOMATCH_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nomatch_o |-> (cs_no == '1 && !ta_o)); // R9
endmodule

// File: rtl/csel_unit.sv
module csel_unit
  import csel_pkg::*;
#(
  parameter int unsigned NBANK = 8,
  localparam int unsigned RA_W = $clog2(NBANK) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [RA_W-1:0]   reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  input  logic              as_i,
  input  logic [31:0]       addr_i,
  input  logic [3:0]        fc_i,
  input  logic              rw_i,
  output logic [NBANK-1:0]  cs_no,
  output logic [1:0]        port_size_o,
  output logic              ta_o,
  output logic              nomatch_o
);
  logic [NBANK-1:0][WORD_W-1:0] base_w, opt_w;
  logic [NBANK-1:0]             hit_w, sel_oh;
  logic [PS_W-1:0]              sel_ps;
  logic [TC_W-1:0]              sel_code;

  csel_regs #(.NBANK(NBANK)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(reg_we_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i), .base_o(base_w), .opt_o(opt_w)
  );

  csel_match #(.NBANK(NBANK)) u_match (
    .base_i(base_w), .opt_i(opt_w), .addr_i(addr_i), .fc_i(fc_i), .rw_i(rw_i),
    .hit_o(hit_w)
  );

  // lowest-numbered hit wins
  always_comb begin
    sel_oh   = '0;
    sel_ps   = '0;
    sel_code = '0;
    for (int b = NBANK - 1; b >= 0; b--) begin
      if (hit_w[b]) begin
        sel_oh   = '0;
        sel_oh[b] = 1'b1;
        sel_ps   = opt_w[b][PS_LSB +: PS_W];
        sel_code = opt_w[b][TC_LSB +: TC_W];
      end
    end
  end

  csel_cycle #(.NBANK(NBANK)) u_cycle (
    .clk_i(clk_i), .rst_ni(rst_ni), .as_i(as_i), .sel_i(sel_oh),
    .ps_i(sel_ps), .code_i(sel_code), .cs_no(cs_no),
    .port_size_o(port_size_o), .ta_o(ta_o), .nomatch_o(nomatch_o)
  );

  AST_ONE_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~cs_no)); // R5
  AST_CPU_SPACE_NO_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(as_i) && fc_i == FC_CPU_SPACE) |=> (cs_no == '1)); // R4
  AST_PS_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_no == '1) |-> (port_size_o == '0)); // R7
endmodule

// File: tb/tb_csel_unit.sv
module tb_csel_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        as = 1'b0;
  logic [31:0] addr = '0;
  logic [3:0]  fc = '0;
  logic        rw = 1'b1;
  logic [7:0]  cs_n;
  logic [1:0]  ps;
  logic        ta, nm;

  int total = 0, bad = 0, cyc = 0;
  bit finished = 0;

  always #2 clk = ~clk;  // 250 MHz

  csel_unit dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .as_i(as), .addr_i(addr), .fc_i(fc), .rw_i(rw),
    .cs_no(cs_n), .port_size_o(ps), .ta_o(ta), .nomatch_o(nm)
  );

  // ---------------- behavioural reference ----------------
  logic [31:0] m_base [8];
  logic [31:0] m_opt  [8];
  int m_st = 0, m_cnt = 0, m_sel = -1;

  function automatic int pick(input logic [31:0] a, input logic [3:0] f, input logic r);
    for (int b = 0; b < 8; b++) begin
      if (m_base[b][0] && ((a ^ m_base[b]) & m_opt[b] & 32'h0FFF_F800) == 0 &&
          ((f ^ m_base[b][10:7]) & m_opt[b][10:7]) == 0 &&
          (r || m_base[b][2]) && f != 4'd7)
        return b;
    end
    return -1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_sel = -1;
    end else begin
      case (m_st)
        0: if (as) begin
             m_sel = pick(addr, fc, rw);
             if (m_sel >= 0) begin
               m_st = 1;
               m_cnt = (m_opt[m_sel][3:0] == 0) ? 0 : int'(m_opt[m_sel][3:0]) - 1;
             end else m_st = 2;
           end
        1: if (m_cnt == 0) m_st = 3; else m_cnt--;
        2: m_st = 3;
        default: if (!as) m_st = 0;
      endcase
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      logic [7:0] e_cs;
      logic [1:0] e_ps;
      e_cs = (m_st == 1) ? ~(8'h1 << m_sel) : 8'hFF;
      e_ps = (m_st == 1) ? m_opt[m_sel][5:4] : 2'b00;
      check(cs_n == e_cs, "R5", "model cs", cs_n, e_cs);
      check(ta == (m_st == 1 && m_cnt == 0), "R6", "model ta", ta, (m_st == 1 && m_cnt == 0));
      check(nm == (m_st == 2), "R9", "model nomatch", nm, (m_st == 2));
      check(ps == e_ps, "R7", "model port size", ps, e_ps);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(input int bank, input bit opt_w, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = {opt_w, 3'(bank)}; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
    if (opt_w) m_opt[bank] = d; else m_base[bank] = d;
  endtask

  task automatic run(input logic [31:0] a, input logic [3:0] f, input logic r,
                     input int eb, input int ew, input logic [1:0] eps, input string req);
    int got_bank = -1, ta_at = -1;
    bit nm_seen = 0;
    logic [1:0] got_ps = 2'b00;
    @(negedge clk);
    as = 1'b1; addr = a; fc = f; rw = r;
    for (int k = 1; k <= 40; k++) begin
      @(negedge clk);
      if (cs_n != 8'hFF && got_bank < 0) begin
        for (int b = 0; b < 8; b++) if (!cs_n[b]) got_bank = b;
        got_ps = ps;
      end
      if (ta) begin ta_at = k; break; end
      if (nm) begin nm_seen = 1; break; end
    end
    if (eb < 0) begin
      check(nm_seen, req, "no-match pulse", nm_seen, 1);
      check(got_bank == -1, req, "no select", got_bank, -1);
    end else begin
      check(got_bank == eb, req, "selected bank", got_bank, eb);
      check(ta_at - 1 == ew, req, "wait states", ta_at - 1, ew);
      check(got_ps == eps, req, "port size", got_ps, eps);
    end
    // R10: strobe held, select released and no further acknowledge
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      check(cs_n == 8'hFF && !ta, "R10", "released while strobe held", cs_n, 8'hFF);
    end
    as = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic summary();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000 && !finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      summary();
    end
  end

  initial begin
    for (int b = 0; b < 8; b++) begin m_base[b] = '0; m_opt[b] = '0; end
    repeat (3) @(negedge clk);
    // R1: reset state
    check(cs_n == 8'hFF && !ta && !nm && ps == 2'b00, "R1", "reset outputs", cs_n, 8'hFF);
    rst_n = 1'b1;
    @(negedge clk);
    run(32'h0400_1010, 4'd5, 1'b1, -1, 0, 2'b00, "R1");

    // windows at 2 KB granularity; R11 addressing
    wr(7, 0, 32'h0400_1005); wr(7, 1, 32'h0FFF_F822);
    wr(6, 0, 32'h0400_1805); wr(6, 1, 32'h0FFF_F821);
    run(32'h0400_1010, 4'd5, 1'b1, 7, 1, 2'b10, "R2");
    run(32'h0400_1FFC, 4'd5, 1'b1, 6, 0, 2'b10, "R2");
    run(32'hF400_1010, 4'd5, 1'b1, 7, 1, 2'b10, "R2");  // upper nibble ignored
    run(32'h0400_2000, 4'd5, 1'b1, -1, 0, 2'b00, "R2");
    wr(6, 1, 32'h0FFF_F823);                             // R11: only bank 6 option changes
    run(32'h0400_1800, 4'd1, 1'b1, 6, 2, 2'b10, "R11");
    run(32'h0400_1000, 4'd1, 1'b1, 7, 1, 2'b10, "R11");

    // wide mask, code 0 saturates; overlap priority; valid gate; code 15
    wr(0, 0, 32'h0010_0005); wr(0, 1, 32'h0FF0_0010);
    wr(3, 0, 32'h0010_0005); wr(3, 1, 32'h0FF0_002F);
    run(32'h001A_BCDE, 4'd1, 1'b1, 0, 0, 2'b01, "R6");
    run(32'h0010_0000, 4'd1, 1'b1, 0, 0, 2'b01, "R5");
    wr(0, 0, 32'h0010_0004);
    run(32'h0010_0000, 4'd1, 1'b1, 3, 14, 2'b10, "R3");

    // function-code compare
    wr(2, 0, 32'h0080_0085); wr(2, 1, 32'h0FF0_01B3);
    run(32'h0081_2345, 4'd5, 1'b1, 2, 2, 2'b11, "R4");
    run(32'h0081_2345, 4'd2, 1'b1, -1, 0, 2'b00, "R4");
    run(32'h0400_1010, 4'd7, 1'b1, -1, 0, 2'b00, "R4");  // CPU space

    // write permission
    wr(5, 0, 32'h0200_0001); wr(5, 1, 32'h0F00_0011);
    run(32'h0234_5678, 4'd1, 1'b1, 5, 0, 2'b01, "R8");
    run(32'h0234_5678, 4'd1, 1'b0, -1, 0, 2'b00, "R8");
    wr(4, 0, 32'h0200_0005); wr(4, 1, 32'h0F00_0012);
    run(32'h0234_5678, 4'd1, 1'b0, 4, 1, 2'b01, "R8");
    run(32'h0400_1010, 4'd1, 1'b0, 7, 1, 2'b10, "R7");
    run(32'h0900_0000, 4'd1, 1'b1, -1, 0, 2'b00, "R9");
    summary();
  end
endmodule